// File: doc/BRIEF.md
# SDRAM Command Spacing Timer

This block sits in the command path of a synchronous DRAM controller. It holds off commands that would come too soon after earlier ones. Three event strobes drive it: a write command, an auto-refresh command and an exit from self-refresh. From these it keeps three permission outputs, one each for an explicit precharge, a bank activate and any command at all. It also gives a one-cycle pulse that marks when an automatic precharge may begin after a write.

The lengths of the hold-offs come from three configuration inputs:

- **Write-recovery bit.** Its meaning depends on the bank-active-mode flag.
  - With the flag set, the bit sets how long an explicit precharge stays blocked after a write.
  - With the flag clear, it sets the delay from the write to the automatic-precharge pulse.
- **Refresh-recovery field (two bits).** Both refresh gaps use it, with different offsets.
- **Bank-active-mode flag.**

Each gap has its own down-counter. The counter takes the configuration at the strobe that starts it. A strobe that arrives during a countdown lengthens the gap when its gap is longer and otherwise leaves it unchanged. The command sequencer combines the three permission outputs as it needs.

Top module: `sdram_cmd_spacer`

## Requirements
- R1: After reset is released, pre_ok, act_ok and cmd_ok are 1, and apre_start and cfg_err are 0.
- R2: A write strobe in cycle t with cfg_bank_act=0 pulses apre_start for exactly one cycle, in cycle t+W+1. W is 1 when cfg_wr_rec=0 and 2 when cfg_wr_rec=1. Such a write leaves pre_ok at 1.
- R3: A write strobe in cycle t with cfg_bank_act=1 drives pre_ok low in cycles t+1 to t+W, using the W of R2. It makes no apre_start pulse.
- R4: The refresh-recovery code on cfg_ref_rec maps to a base value B: 2'b00 gives 2, 2'b01 gives 3, and both 2'b10 and the reserved 2'b11 give 4.
- R5: An auto-refresh strobe in cycle t holds act_ok low for exactly B+2 cycles, starting in cycle t+1.
- R6: A self-refresh-exit strobe in cycle t holds cmd_ok low for exactly B+1 cycles, starting in cycle t+1.
- R7: A strobe that arrives while its own hold-off is still running ends the hold-off at the later of the old end and the new end.
- R8: If cfg_ref_rec holds 2'b11 in any cycle, cfg_err is 1 from the next cycle on. It stays 1 until reset.
- R9: The configuration is sampled only in the strobe cycle. Changing it during a countdown does not change that countdown.
- R10: Each event affects only its own output:
  - a write affects pre_ok or apre_start;
  - an auto-refresh affects act_ok;
  - a self-refresh exit affects cmd_ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_cmd_stb | input | 1 | A write command is issued in this cycle |
| aref_cmd_stb | input | 1 | An auto-refresh command is issued in this cycle |
| srx_stb | input | 1 | Self-refresh is exited in this cycle |
| cfg_wr_rec | input | 1 | Write recovery: 0 gives 1 cycle, 1 gives 2 cycles |
| cfg_ref_rec | input | 2 | Refresh-recovery code (see R4) |
| cfg_bank_act | input | 1 | Bank-active mode: write recovery blocks explicit precharge |
| pre_ok | output | 1 | An explicit precharge may be issued |
| act_ok | output | 1 | A bank activate may be issued |
| cmd_ok | output | 1 | Any command may be issued |
| apre_start | output | 1 | One-cycle pulse: the automatic precharge after a write may start |
| cfg_err | output | 1 | Sticky flag: the reserved refresh-recovery code was seen |

## Verification
The hardest behaviour to reach from the ports is a second strobe landing partway through a running hold-off, both when it is shorter and when it is longer than what remains. The bench reaches it by firing a second strobe at a chosen sample inside the measurement window, with a different code. It then counts the total number of low cycles. In every case the bench also changes the configuration inputs right after the strobe, so a countdown that reads live configuration shows up as a wrong length.

// File: rtl/sdram_spc_pkg.sv
package sdram_spc_pkg;

  localparam int CNT_W  = 3;
  localparam int RREC_W = 2;

  // Base refresh-recovery value; the reserved top code folds onto the largest.
  function automatic logic [CNT_W-1:0] rrec_base(input logic [RREC_W-1:0] code);
    logic [CNT_W-1:0] b;
    if (code == {RREC_W{1'b1}}) b = CNT_W'(4);
    else                        b = CNT_W'(2) + CNT_W'(code);
    return b;
  endfunction

  function automatic logic [CNT_W-1:0] wrec_len(input logic code);
    return code ? CNT_W'(2) : CNT_W'(1);
  endfunction

endpackage

// File: rtl/spc_rst_sync.sv
module spc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spc_holdoff_ctr.sv
module spc_holdoff_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         allow,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         allow_q, allow_d;
  logic         expire_q, expire_d;
  logic [W-1:0] rem;
  logic [W-1:0] len_m1;

  always_comb begin
    rem      = (cnt_q != '0) ? (cnt_q - ONE) : '0;
    len_m1   = len - ONE;
    cnt_d    = cnt_q;
    allow_d  = allow_q;
    expire_d = 1'b0;
    if (load) begin
      cnt_d   = (len_m1 > rem) ? len_m1 : rem;
      allow_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d   = cnt_q - ONE;
      allow_d = 1'b0;
    end else begin
      allow_d  = 1'b1;
      expire_d = !allow_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      allow_q  <= 1'b1;
      expire_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      allow_q  <= allow_d;
      expire_q <= expire_d;
    end
  end

  assign allow  = allow_q;
  assign expire = expire_q;
endmodule

// File: rtl/sdram_cmd_spacer.sv
module sdram_cmd_spacer
  import sdram_spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd_stb,
  input  logic              aref_cmd_stb,
  input  logic              srx_stb,
  input  logic              cfg_wr_rec,
  input  logic [RREC_W-1:0] cfg_ref_rec,
  input  logic              cfg_bank_act,
  output logic              pre_ok,
  output logic              act_ok,
  output logic              cmd_ok,
  output logic              apre_start,
  output logic              cfg_err
);
  localparam int NUM_CTR = 4;
  localparam int IDX_WBA = 0;
  localparam int IDX_WAP = 1;
  localparam int IDX_ARF = 2;
  localparam int IDX_SRX = 3;

  logic                       rst_sync_n;
  logic [NUM_CTR-1:0]         ld;
  logic [NUM_CTR-1:0]         alw;
  logic [NUM_CTR-1:0]         exp_p;
  logic [NUM_CTR-1:0][CNT_W-1:0] len;
  logic [CNT_W-1:0]           base;
  logic                       err_d, err_q;

  spc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    base         = rrec_base(cfg_ref_rec);
    ld[IDX_WBA]  = wr_cmd_stb &  cfg_bank_act;
    ld[IDX_WAP]  = wr_cmd_stb & ~cfg_bank_act;
    ld[IDX_ARF]  = aref_cmd_stb;
    ld[IDX_SRX]  = srx_stb;
    len[IDX_WBA] = wrec_len(cfg_wr_rec);
    len[IDX_WAP] = wrec_len(cfg_wr_rec);
    len[IDX_ARF] = base + CNT_W'(2);
    len[IDX_SRX] = base + CNT_W'(1);
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    spc_holdoff_ctr #(.W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .load   (ld[g]),
      .len    (len[g]),
      .allow  (alw[g]),
      .expire (exp_p[g])
    );
  end

  always_comb begin
    err_d = err_q | (cfg_ref_rec == {RREC_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign pre_ok     = alw[IDX_WBA];
  assign act_ok     = alw[IDX_ARF];
  assign cmd_ok     = alw[IDX_SRX];
  assign apre_start = exp_p[IDX_WAP];
  assign cfg_err    = err_q;
endmodule

// File: rtl/sdram_cmd_spacer_chk.sv
module sdram_cmd_spacer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_cmd_stb,
  input logic       aref_cmd_stb,
  input logic       srx_stb,
  input logic       cfg_bank_act,
  input logic [1:0] cfg_ref_rec,
  input logic       pre_ok,
  input logic       act_ok,
  input logic       cmd_ok,
  input logic       apre_start,
  input logic       cfg_err
);
  AST_WR_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_stb && cfg_bank_act) |=> !pre_ok); // R3
  AST_WR_AP_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_stb && !cfg_bank_act) |=> !apre_start); // R2
  AST_APRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    apre_start |=> !apre_start); // R2
  AST_AREF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    aref_cmd_stb |=> !act_ok); // R5
  AST_AREF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act_ok) |=> !act_ok); // R5
  AST_SRX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    srx_stb |=> !cmd_ok); // R6
  AST_SRX_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_ok) |=> !cmd_ok); // R6
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ref_rec == 2'b11) |=> cfg_err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R8
endmodule

bind sdram_cmd_spacer sdram_cmd_spacer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wr_cmd_stb   (wr_cmd_stb),
  .aref_cmd_stb (aref_cmd_stb),
  .srx_stb      (srx_stb),
  .cfg_bank_act (cfg_bank_act),
  .cfg_ref_rec  (cfg_ref_rec),
  .pre_ok       (pre_ok),
  .act_ok       (act_ok),
  .cmd_ok       (cmd_ok),
  .apre_start   (apre_start),
  .cfg_err      (cfg_err)
);

// File: tb/test_sdram_cmd_spacer.sv
module test_sdram_cmd_spacer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_cmd_stb, aref_cmd_stb, srx_stb;
  logic       cfg_wr_rec, cfg_bank_act;
  logic [1:0] cfg_ref_rec;
  logic       pre_ok, act_ok, cmd_ok, apre_start, cfg_err;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_spacer i_sdram_cmd_spacer (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd_stb(wr_cmd_stb), .aref_cmd_stb(aref_cmd_stb), .srx_stb(srx_stb),
    .cfg_wr_rec(cfg_wr_rec), .cfg_ref_rec(cfg_ref_rec), .cfg_bank_act(cfg_bank_act),
    .pre_ok(pre_ok), .act_ok(act_ok), .cmd_ok(cmd_ok),
    .apre_start(apre_start), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int base_of(input logic [1:0] c);
    return (c == 2'b11) ? 4 : 2 + int'(c);
  endfunction

  task automatic set_stb(input int kind, input logic v);
    wr_cmd_stb   = (kind == 0) ? v : 1'b0;
    aref_cmd_stb = (kind == 1) ? v : 1'b0;
    srx_stb      = (kind == 2) ? v : 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_stb(0, 1'b0);
    cfg_wr_rec = 1'b0; cfg_bank_act = 1'b0; cfg_ref_rec = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // kind: 0 write, 1 auto-refresh, 2 self-refresh exit
  task automatic run_case(input int kind, input logic [1:0] code, input logic wrc,
                          input logic ba, input int retrig_i, input logic [1:0] code2,
                          input int exp_lows, input int exp_apre, input string req);
    int lows = 0;
    int apre_i = 0;
    int side_bad = 0;
    logic watched;
    @(negedge clk);
    cfg_ref_rec = code; cfg_wr_rec = wrc; cfg_bank_act = ba;
    set_stb(kind, 1'b1);
    @(negedge clk);
    set_stb(kind, 1'b0);
    // R9: disturb configuration during countdown
    cfg_ref_rec = (code >= 2'b10) ? 2'b00 : code + 2'b01;
    cfg_wr_rec  = ~wrc;
    for (int i = 1; i <= 12; i++) begin
      watched = (kind == 0) ? !pre_ok : (kind == 1) ? !act_ok : !cmd_ok;
      if (watched) lows++;
      if (apre_start) begin
        if (apre_i == 0) apre_i = i;
        else side_bad++;
      end
      if (kind != 0 && (!pre_ok || apre_start)) side_bad++;
      if (kind != 1 && !act_ok) side_bad++;
      if (kind != 2 && !cmd_ok) side_bad++;
      if (i == retrig_i) begin
        cfg_ref_rec = code2;
        set_stb(kind, 1'b1);
      end else begin
        set_stb(kind, 1'b0);
      end
      @(negedge clk);
    end
    check(lows == exp_lows, {req, " hold-off length"}, lows, exp_lows);
    check(apre_i == exp_apre, {req, " apre_start cycle"}, apre_i, exp_apre);
    check(side_bad == 0, "R10 other outputs undisturbed", side_bad, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(pre_ok == 1'b1, "R1 pre_ok", int'(pre_ok), 1);
    check(act_ok == 1'b1, "R1 act_ok", int'(act_ok), 1);
    check(cmd_ok == 1'b1, "R1 cmd_ok", int'(cmd_ok), 1);
    check(apre_start == 1'b0, "R1 apre_start", int'(apre_start), 0);
    check(cfg_err == 1'b0, "R1 cfg_err", int'(cfg_err), 0);

    // R2 / R3 write recovery sweep
    for (int w = 0; w < 2; w++) begin
      for (int b = 0; b < 2; b++) begin
        if (b == 1) run_case(0, 2'b00, w[0], 1'b1, 0, 2'b00, w + 1, 0, "R3");
        else        run_case(0, 2'b00, w[0], 1'b0, 0, 2'b00, 0, w + 2, "R2");
      end
    end

    // R4 / R5 / R6 refresh sweeps over legal codes, both modes
    for (int c = 0; c < 3; c++) begin
      for (int b = 0; b < 2; b++) begin
        run_case(1, c[1:0], 1'b0, b[0], 0, 2'b00, base_of(c[1:0]) + 2, 0, "R5 R4");
        run_case(2, c[1:0], 1'b1, b[0], 0, 2'b00, base_of(c[1:0]) + 1, 0, "R6 R4");
      end
    end

    // R7 retrigger: longer remaining vs. longer new
    run_case(1, 2'b10, 1'b0, 1'b0, 3, 2'b00, 7, 0, "R7 aref extend");
    run_case(1, 2'b10, 1'b0, 1'b0, 1, 2'b00, 6, 0, "R7 aref keep");
    run_case(2, 2'b10, 1'b0, 1'b0, 1, 2'b00, 5, 0, "R7 srx keep");
    run_case(2, 2'b10, 1'b0, 1'b0, 4, 2'b00, 7, 0, "R7 srx extend");

    // R8 / R4 reserved code
    check(cfg_err == 1'b0, "R8 clear before reserved code", int'(cfg_err), 0);
    run_case(1, 2'b11, 1'b0, 1'b0, 0, 2'b00, 6, 0, "R4 reserved aref");
    check(cfg_err == 1'b1, "R8 set after reserved code", int'(cfg_err), 1);
    run_case(2, 2'b11, 1'b0, 1'b1, 0, 2'b00, 5, 0, "R4 reserved srx");
    cfg_ref_rec = 2'b00;
    repeat (5) @(negedge clk);
    check(cfg_err == 1'b1, "R8 sticky", int'(cfg_err), 1);
    do_reset();
    check(cfg_err == 1'b0, "R8 cleared by reset", int'(cfg_err), 0);
    check(pre_ok && act_ok && cmd_ok, "R1 after second reset", int'(pre_ok && act_ok && cmd_ok), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule